// File: doc/BRIEF.md
# Saturating Wiper Up/Down Stepper

This block runs the fast up/down mode of a digitally controlled potentiometer slave on a two-wire serial bus. A bus front-end turns the bus into single-cycle strobes: one for a START, one for a STOP, and one for each rising edge of the serial clock, carrying the data-line value sampled on that edge.

The block assembles the first two bytes of a transaction. The first byte must carry the step-mode device code `01011`, the two address bits equal to the pins, and a write direction bit of 0. The second byte must be register address 00h. The block requests an acknowledge for each of these two bytes. After the second acknowledge slot it is in step mode. From then on, every bit strobe moves the wiper code by one position: up when the bit is 1, down when it is 0. The code stops at 0 and at full scale and never wraps. A STOP or a new START ends the mode. The wiper keeps its last position.

The bit stream carries a valid strobe and no ready. The serial clock belongs to the bus master and this block never stretches it, so there is no back-pressure. Every strobe is consumed in the cycle it arrives. Only the volatile wiper code is touched. Storage of the result and the analog response belong to other blocks.

Top module: `wiper_stepper`

## Requirements
- R1: After reset, `wiper_o` is mid-scale (64 for a 7-bit wiper), and `ack_o` and `step_active_o` are low.
- R2: A first byte, received MSB first, is acknowledged only when it equals `{5'b01011, addr_pins_i[1], addr_pins_i[0], 1'b0}`. Acknowledge means `ack_o` is high from the cycle after its eighth bit strobe until the ninth strobe. Any other first byte gets no acknowledge, and the block ignores the bus until the next START.
- R3: After an acknowledged first byte, a second byte of 00h is acknowledged in the same way. Any other value gets no acknowledge, and step mode is not entered.
- R4: In step mode (`step_active_o` high, from the cycle after the second acknowledge slot's strobe), a strobe with bit value 1 raises `wiper_o` by one in the next cycle.
- R5: In step mode, a strobe with bit value 0 lowers `wiper_o` by one in the next cycle.
- R6: A rising step at 127 leaves the wiper at 127. A falling step at 0 leaves it at 0.
- R7: A STOP ends step mode and keeps the position. Later bit strobes leave `wiper_o` unchanged.
- R8: A START during step mode ends the mode and keeps the position. The bits that follow are treated as a new first byte and do not move the wiper.
- R9: `ack_o` stays low throughout step mode.
- R10: Bit strobes outside step mode never change `wiper_o`. This includes address bits, acknowledge slots and rejected transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_pins_i | input | 2 | Device address pins {A1, A0} |
| start_i | input | 1 | Single-cycle START strobe |
| stop_i | input | 1 | Single-cycle STOP strobe |
| bit_vld_i | input | 1 | Single-cycle strobe, one per serial clock rising edge |
| bit_val_i | input | 1 | Data-line value sampled with `bit_vld_i` |
| wiper_o | output | 7 | Current wiper code |
| step_active_o | output | 1 | High while in step mode |
| ack_o | output | 1 | Request to pull the data line low in the current acknowledge slot |

## Verification
The assertions assume that the front-end never raises START, STOP and a bit strobe in the same cycle, and that every strobe lasts exactly one cycle. The bench drives each strobe as a one-cycle pulse followed by an idle cycle, so no two events ever share an edge. A sweep covers every combination of pin setting, address bits and direction bit. The stepping stream runs past both ends of the range so that saturation is reached from each side.

// File: rtl/wiper_stepper_pkg.sv
package wiper_stepper_pkg;
  localparam int BYTE_W = 8;
  localparam int ID_W   = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK1,
    ST_REG,
    ST_ACK2,
    ST_STEP,
    ST_SKIP
  } wstep_state_e;
endpackage

// File: rtl/wiper_byte_shift.sv
module wiper_byte_shift
  import wiper_stepper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              last_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-2:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[BYTE_W-3:0], bit_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // The byte presented includes the bit arriving now
  assign byte_o = {sh_q, bit_i};
  assign last_o = (cnt_q == LAST_CNT);
endmodule

// File: rtl/wiper_sat_step.sv
module wiper_sat_step #(
  parameter int WIPER_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic               up_i,
  output logic [WIPER_W-1:0] wiper_o
);
  localparam logic [WIPER_W-1:0] TOP = '1;
  localparam logic [WIPER_W-1:0] BOT = '0;
  localparam logic [WIPER_W-1:0] MID = {1'b1, {(WIPER_W-1){1'b0}}};

  logic [WIPER_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= MID;
    end else if (step_i) begin
      if (up_i && pos_q != TOP)
        pos_q <= pos_q + 1'b1;
      else if (!up_i && pos_q != BOT)
        pos_q <= pos_q - 1'b1;
    end
  end

  assign wiper_o = pos_q;
endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
  import wiper_stepper_pkg::*;
#(
  parameter logic [ID_W-1:0]   DEV_ID   = 5'b01011,
  parameter logic [BYTE_W-1:0] REG_ADDR = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pins_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              bit_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              last_i,
  output logic              shift_o,
  output logic              step_o,
  output logic              active_o,
  output logic              ack_o
);
  wstep_state_e state_q, state_d;

  logic [BYTE_W-1:0] want_first;
  logic              hit_first, hit_reg;

  assign want_first = {DEV_ID, pins_i, 1'b0};
  assign hit_first  = (byte_i == want_first);
  assign hit_reg    = (byte_i == REG_ADDR);

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = ST_ADDR;
    end else if (stop_i) begin
      state_d = ST_IDLE;
    end else if (bit_vld_i) begin
      unique case (state_q)
        ST_ADDR: if (last_i) state_d = hit_first ? ST_ACK1 : ST_SKIP;
        ST_ACK1: state_d = ST_REG;
        ST_REG:  if (last_i) state_d = hit_reg ? ST_ACK2 : ST_SKIP;
        ST_ACK2: state_d = ST_STEP;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign shift_o  = bit_vld_i && !start_i && !stop_i &&
                    (state_q == ST_ADDR || state_q == ST_REG);
  assign step_o   = bit_vld_i && !start_i && !stop_i && (state_q == ST_STEP);
  assign active_o = (state_q == ST_STEP);
  assign ack_o    = (state_q == ST_ACK1) || (state_q == ST_ACK2);
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper
  import wiper_stepper_pkg::*;
#(
  parameter int                WIPER_W  = 7,
  parameter logic [ID_W-1:0]   DEV_ID   = 5'b01011,
  parameter logic [BYTE_W-1:0] REG_ADDR = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         addr_pins_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               bit_vld_i,
  input  logic               bit_val_i,
  output logic [WIPER_W-1:0] wiper_o,
  output logic               step_active_o,
  output logic               ack_o
);
  logic [BYTE_W-1:0] byte_w;
  logic              last_w, shift_w, step_w;

  wiper_byte_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_i),
    .shift_i (shift_w),
    .bit_i   (bit_val_i),
    .byte_o  (byte_w),
    .last_o  (last_w)
  );

  wiper_step_ctrl #(.DEV_ID(DEV_ID), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_i    (addr_pins_i),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .bit_vld_i (bit_vld_i),
    .byte_i    (byte_w),
    .last_i    (last_w),
    .shift_o   (shift_w),
    .step_o    (step_w),
    .active_o  (step_active_o),
    .ack_o     (ack_o)
  );

  wiper_sat_step #(.WIPER_W(WIPER_W)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step_w),
    .up_i    (bit_val_i),
    .wiper_o (wiper_o)
  );
endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
  parameter int WIPER_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               stop_i,
  input logic               bit_vld_i,
  input logic               bit_val_i,
  input logic [WIPER_W-1:0] wiper_o,
  input logic               step_active_o,
  input logic               ack_o
);
  localparam logic [WIPER_W-1:0] TOP = '1;
  localparam logic [WIPER_W-1:0] BOT = '0;

  logic plain_bit;
  assign plain_bit = bit_vld_i && !start_i && !stop_i;

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_active_o && plain_bit && bit_val_i && wiper_o != TOP
    |=> wiper_o == $past(wiper_o) + 1'b1);

  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_active_o && plain_bit && !bit_val_i && wiper_o != BOT
    |=> wiper_o == $past(wiper_o) - 1'b1);

  // R6
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_active_o && plain_bit && bit_val_i && wiper_o == TOP
    |=> wiper_o == TOP);

  // R6
  sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_active_o && plain_bit && !bit_val_i && wiper_o == BOT
    |=> wiper_o == BOT);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_active_o |=> $stable(wiper_o));

  // R9
  no_ack_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_active_o |-> !ack_o);

  // R7
  stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> !step_active_o);
endmodule

bind wiper_stepper wiper_stepper_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .stop_i        (stop_i),
  .bit_vld_i     (bit_vld_i),
  .bit_val_i     (bit_val_i),
  .wiper_o       (wiper_o),
  .step_active_o (step_active_o),
  .ack_o         (ack_o)
);

// File: tb/wiper_stepper_bench.sv
module wiper_stepper_bench;
  localparam int W   = 7;
  localparam int TOP = 127;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   pins = 2'd0;
  logic         start_s = 1'b0, stop_s = 1'b0, bvld = 1'b0, bval = 1'b0;
  logic [W-1:0] wiper;
  logic         active, ack;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int model;

  always #10 clk = ~clk;

  wiper_stepper u_wiper_stepper (
    .clk(clk), .rst_n(rst_n), .addr_pins_i(pins), .start_i(start_s),
    .stop_i(stop_s), .bit_vld_i(bvld), .bit_val_i(bval),
    .wiper_o(wiper), .step_active_o(active), .ack_o(ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_bit(input bit b);
    @(negedge clk); bvld = 1'b1; bval = b;
    @(negedge clk); bvld = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start_s = 1'b1;
    @(negedge clk); start_s = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_s = 1'b1;
    @(negedge clk); stop_s = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) pulse_bit(b[i]);
    acked = ack;
    pulse_bit(1'b0);
  endtask

  task automatic enter_mode();
    bit a;
    do_start();
    send_byte({5'b01011, pins, 1'b0}, a);
    chk(a, "R2 first byte ack", a, 1);
    send_byte(8'h00, a);
    chk(a, "R3 register byte ack", a, 1);
    chk(active, "R4 mode entered", active, 1);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wiper == 7'd64, "R1 wiper", wiper, 64);
    chk(!ack, "R1 ack", ack, 0);
    chk(!active, "R1 active", active, 0);
    model = 64;

    // R2/R3/R10 sweep: pins x address bits x direction bit
    for (int p = 0; p < 4; p++) begin
      pins = 2'(p);
      for (int ab = 0; ab < 4; ab++) begin
        for (int rw = 0; rw < 2; rw++) begin
          bit exp_a;
          exp_a = (ab == p) && (rw == 0);
          do_start();
          send_byte({5'b01011, 2'(ab), 1'(rw)}, a);
          chk(a == exp_a, "R2 address match", a, exp_a);
          send_byte(8'h00, a);
          chk(a == exp_a, "R3 register ack", a, exp_a);
          chk(active == exp_a, "R3 mode entry", active, exp_a);
          do_stop();
          chk(!active, "R7 stop exits", active, 0);
          chk(wiper == 7'(model), "R10 no move", wiper, model);
        end
      end
      // wrong device code
      do_start();
      send_byte({5'b01010, pins, 1'b0}, a);
      chk(!a, "R2 wrong code", a, 0);
      pulse_bit(1'b1);
      chk(wiper == 7'(model), "R10 rejected stream", wiper, model);
      do_stop();
    end

    // R3: wrong register address, following bits must not step
    pins = 2'd2;
    do_start();
    send_byte({5'b01011, pins, 1'b0}, a);
    chk(a, "R2 ack before bad reg", a, 1);
    send_byte(8'h01, a);
    chk(!a, "R3 bad reg no ack", a, 0);
    for (int i = 0; i < 4; i++) pulse_bit(1'b1);
    chk(wiper == 7'(model), "R10 after bad reg", wiper, model);
    do_stop();

    // R4/R5/R6/R9 stepping sweep across both ends
    enter_mode();
    for (int i = 0; i < 70; i++) begin
      pulse_bit(1'b1);
      model = (model < TOP) ? model + 1 : TOP;
      chk(wiper == 7'(model), (model == TOP) ? "R6 top saturate" : "R4 step up", wiper, model);
      chk(!ack, "R9 no ack", ack, 0);
    end
    for (int i = 0; i < 135; i++) begin
      pulse_bit(1'b0);
      model = (model > 0) ? model - 1 : 0;
      chk(wiper == 7'(model), (model == 0) ? "R6 bottom saturate" : "R5 step down", wiper, model);
    end
    for (int i = 0; i < 40; i++) begin
      bit b;
      b = ((i % 3) != 2);
      pulse_bit(b);
      model = b ? ((model < TOP) ? model + 1 : TOP) : ((model > 0) ? model - 1 : 0);
      chk(wiper == 7'(model), "R4 R5 mixed stream", wiper, model);
    end

    // R7: stop holds position, later bits ignored
    do_stop();
    chk(!active, "R7 inactive", active, 0);
    for (int i = 0; i < 5; i++) pulse_bit(1'b1);
    chk(wiper == 7'(model), "R7 held after stop", wiper, model);

    // R8: START mid-stream
    enter_mode();
    for (int i = 0; i < 3; i++) pulse_bit(1'b1);
    model = model + 3;
    do_start();
    chk(!active, "R8 start exits", active, 0);
    chk(wiper == 7'(model), "R8 position kept", wiper, model);
    for (int i = 0; i < 6; i++) pulse_bit(1'b0);
    chk(wiper == 7'(model), "R8 bits after start", wiper, model);
    do_stop();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule